// File: doc/BRIEF.md
# UART Receive Line Status Flags

This block keeps the three receive-side flags of a 16550-style serial port status byte: data available, overrun and parity error. It watches the character-complete strobe from the receive deserialiser together with the received data and parity bit. It also watches the CPU's reads of the receive buffer and of the status byte. From these inputs it decides, in the same cycle as each completed character, whether that character may be written into the receive storage.

The block works in two storage modes. In single-buffer mode there is one holding register. A character that arrives while the previous one is still unread replaces it and raises overrun. In FIFO mode the block tracks how full the receive FIFO is and keeps a parity tag for every stored character. A character that arrives while the FIFO is full is dropped and the FIFO contents are kept. A stored parity error is reported only when its character reaches the head of the FIFO. A change of mode flushes the tracked occupancy.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `status_o` is all zero and `store_o` is 0.
- R2: The cycle after a character is accepted (`store_o`=1), status bit 0 (data ready) is 1.
- R3: Data ready returns to 0 only in the cycle after the read that empties the storage (the holding register, or the last FIFO entry), or after a mode-change flush.
- R4: Single-buffer mode (`fifo_mode_i`=0): a completed character that arrives while the holding register is occupied and not read in the same cycle is still stored (`store_o`=1, it overwrites the old one). Status bit 1 (overrun) is 1 in the next cycle, and a single buffer read then empties the storage.
- R5: FIFO mode (`fifo_mode_i`=1): a completed character that arrives while DEPTH entries are held and no buffer read occurs in that cycle gives `store_o`=0, and overrun is 1 in the next cycle. The FIFO keeps DEPTH entries. If a buffer read occurs in the same cycle, the character is stored and there is no overrun.
- R6: Overrun clears in the cycle after a status read (`lsr_rd_i`), unless a new overrun occurs in that read cycle.
- R7: A character has bad parity when the count of ones in its data bits plus its parity bit is odd with `even_sel_i`=1, or even with `even_sel_i`=0. In single-buffer mode, status bit 2 (parity error) is 1 in the cycle after a completed character with bad parity.
- R8: In FIFO mode, the parity error flag is set in the cycle after a character with bad parity becomes the FIFO head, and not while it waits behind other entries.
- R9: Parity error clears in the cycle after a status read, unless a new parity event occurs in that read cycle.
- R10: When an overrun or parity event coincides with a status read, the flag is 1 in the next cycle.
- R11: Bits 7:3 of `status_o` are always 0.
- R12: A buffer read while the storage is empty changes no flag.
- R13: A change of `fifo_mode_i` flushes the tracked storage, so data ready is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode_i | input | 1 | 1 = FIFO mode, 0 = single holding register |
| char_done_i | input | 1 | One-cycle strobe: a character is complete in the shift register |
| rx_data_i | input | DATA_W | Data bits of the completed character |
| rx_par_i | input | 1 | Received parity bit of the completed character |
| even_sel_i | input | 1 | 1 = even parity expected, 0 = odd |
| rbr_rd_i | input | 1 | CPU read of the receive buffer |
| lsr_rd_i | input | 1 | CPU read of the status byte |
| store_o | output | 1 | Write enable for the completed character into the receive storage |
| status_o | output | 8 | Bit 0 data ready, bit 1 overrun, bit 2 parity error, other bits 0 |

## Verification
The bench fills the FIFO to exactly DEPTH entries and sends one more character. A design that stored that character, or kept the old overwrite rule of single-buffer mode in FIFO mode, would assert `store_o` and corrupt the queue. The bench also queues a bad-parity character behind a good one. A design that reported parity on arrival rather than at the head would raise the flag one read too early. It drives status reads in the same cycle as new error events, where a clear-priority flag would lose the event. It also checks that data ready stays up through every FIFO read except the last, and that reads of an empty buffer and mode changes leave the flags in the expected state.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

  localparam int STAT_W = 8;
  localparam int DR_BIT = 0;
  localparam int OE_BIT = 1;
  localparam int PE_BIT = 2;

  // data_odd: XOR of all data bits. even_sel=1 expects an even total count of ones.
  function automatic logic parity_bad(input logic data_odd, input logic par_bit,
                                      input logic even_sel);
    return data_odd ^ par_bit ^ ~even_sel;
  endfunction

  // Sticky flag next state: a set has priority over a clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/lsr_sticky_flag.sv
module lsr_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  import uart_lsr_pkg::*;

  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= sticky_next(flag_q, set_i, clr_i);
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R10
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o); // R6

endmodule

// File: rtl/rx_occupancy.sv
module rx_occupancy #(
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fifo_mode_i,
  input  logic                           flush_i,
  input  logic                           push_i,
  input  logic                           pop_i,
  input  logic                           tag_i,
  output logic [$clog2(DEPTH+1)-1:0]     count_o,
  output logic                           full_o,
  output logic                           empty_o,
  output logic                           head_bad_evt_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] CAP_FIFO = CW'(DEPTH);
  localparam logic [CW-1:0] ONE      = CW'(1);

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [CW-1:0]    count_q, count_d;
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [DEPTH-1:0] tags_q;
  logic             rd_ok;
  logic             fifo_wr, fifo_rd;
  logic             new_head_from_push, new_head_from_pop;

  assign empty_o = (count_q == '0);
  assign full_o  = fifo_mode_i ? (count_q == CAP_FIFO) : (count_q == ONE);
  assign rd_ok   = pop_i && !empty_o;
  assign fifo_wr = fifo_mode_i && !flush_i && push_i;
  assign fifo_rd = fifo_mode_i && !flush_i && rd_ok;

  always_comb begin
    if (flush_i)          count_d = '0;
    else if (fifo_mode_i) count_d = count_q + CW'(push_i) - CW'(rd_ok);
    else if (push_i)      count_d = ONE;
    else if (rd_ok)       count_d = '0;
    else                  count_d = count_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      tags_q   <= '0;
    end else begin
      count_q <= count_d;
      if (flush_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (fifo_wr) begin
          tags_q[wr_ptr_q] <= tag_i;
          wr_ptr_q         <= ptr_step(wr_ptr_q);
        end
        if (fifo_rd) rd_ptr_q <= ptr_step(rd_ptr_q);
      end
    end
  end

  // Which character becomes the FIFO head in the next cycle.
  assign new_head_from_push = fifo_wr && (empty_o || (count_q == ONE && rd_ok));
  assign new_head_from_pop  = fifo_rd && (count_q > ONE);
  assign head_bad_evt_o = (new_head_from_push && tag_i) ||
                          (new_head_from_pop && tags_q[ptr_step(rd_ptr_q)]);

  assign count_o = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CAP_FIFO); // R5
  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (!full_o || rd_ok)); // R5
  AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode_i && !flush_i) |=> (count_o <= ONE)); // R4

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode_i,
  input  logic              char_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              even_sel_i,
  input  logic              rbr_rd_i,
  input  logic              lsr_rd_i,
  output logic              store_o,
  output logic [7:0]        status_o
);
  import uart_lsr_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  logic          mode_q;
  logic          mode_chg;
  logic          char_bad;
  logic          ovr_evt;
  logic          pe_evt;
  logic          head_bad_evt;
  logic          occ_full, occ_empty;
  logic [CW-1:0] occ_count;
  logic          oe_flag, pe_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode_i;
  end

  assign mode_chg = (fifo_mode_i != mode_q);
  assign char_bad = parity_bad(^rx_data_i, rx_par_i, even_sel_i);
  assign ovr_evt  = char_done_i && occ_full && !rbr_rd_i;
  assign store_o  = fifo_mode_i ? (char_done_i && !ovr_evt) : char_done_i;
  assign pe_evt   = fifo_mode_i ? head_bad_evt : (char_done_i && char_bad);

  rx_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk            (clk),
    .rst_n          (rst_n),
    .fifo_mode_i    (fifo_mode_i),
    .flush_i        (mode_chg),
    .push_i         (store_o),
    .pop_i          (rbr_rd_i),
    .tag_i          (char_bad),
    .count_o        (occ_count),
    .full_o         (occ_full),
    .empty_o        (occ_empty),
    .head_bad_evt_o (head_bad_evt)
  );

  lsr_sticky_flag u_oe (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ovr_evt),
    .clr_i  (lsr_rd_i),
    .flag_o (oe_flag)
  );

  lsr_sticky_flag u_pe (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (pe_evt),
    .clr_i  (lsr_rd_i),
    .flag_o (pe_flag)
  );

  always_comb begin
    status_o         = '0;
    status_o[DR_BIT] = !occ_empty;
    status_o[OE_BIT] = oe_flag;
    status_o[PE_BIT] = pe_flag;
  end

  AST_OVR_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> status_o[OE_BIT]); // R4
  AST_FIFO_DROPS_ON_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode_i && ovr_evt) |-> !store_o); // R5
  AST_STORE_GIVES_DR: assert property (@(posedge clk) disable iff (!rst_n)
    (store_o && !mode_chg) |=> status_o[DR_BIT]); // R2
  AST_DR_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[DR_BIT]) |-> ($past(rbr_rd_i) || $past(mode_chg))); // R3
  AST_SINGLE_PE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode_i && char_done_i && char_bad) |=> status_o[PE_BIT]); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !status_o[DR_BIT]); // R13
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7:3] == 5'd0); // R11

endmodule

// File: tb/uart_rx_status_tb_top.sv
`timescale 1ns/1ps
module uart_rx_status_tb_top;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_mode_i = 1'b0;
  logic       char_done_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_par_i = 1'b0;
  logic       even_sel_i = 1'b1;
  logic       rbr_rd_i = 1'b0;
  logic       lsr_rd_i = 1'b0;
  logic       store_o;
  logic [7:0] status_o;

  always #2.5 clk = ~clk;

  uart_rx_status #(.DEPTH(DEPTH), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode_i(fifo_mode_i), .char_done_i(char_done_i),
    .rx_data_i(rx_data_i), .rx_par_i(rx_par_i), .even_sel_i(even_sel_i),
    .rbr_rd_i(rbr_rd_i), .lsr_rd_i(lsr_rd_i), .store_o(store_o), .status_o(status_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      req_q[$];

  // Reference model state
  int  m_cnt = 0;
  bit  m_tags[$];
  bit  m_oe = 0, m_pe = 0;
  bit  m_mode = 0, m_prev = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic drive(input bit done, input bit [7:0] d, input bit p, input bit ev,
                       input bit rbr, input bit lsr, input string req);
    int  ones;
    bit  bad, full, rd, ovr, st, pe_evt;
    @(negedge clk);
    fifo_mode_i = m_mode; char_done_i = done; rx_data_i = d; rx_par_i = p;
    even_sel_i = ev; rbr_rd_i = rbr; lsr_rd_i = lsr;
    ones = $countones({d, p});
    bad  = ev ? (ones % 2 == 1) : (ones % 2 == 0);
    ovr = 0; pe_evt = 0; st = done;
    if (m_mode != m_prev) begin
      m_cnt = 0; m_tags.delete();
    end else begin
      full = (m_cnt == (m_mode ? DEPTH : 1));
      rd   = rbr && (m_cnt > 0);
      ovr  = done && full && !rbr;
      if (m_mode) begin
        st = done && !ovr;
        if (st && m_cnt == 0) pe_evt = bad;
        if (rd) void'(m_tags.pop_front());
        if (st) m_tags.push_back(bad);
        if (rd && m_tags.size() > 0 && m_tags[0]) pe_evt = 1;
        m_cnt = m_tags.size();
      end else begin
        pe_evt = done && bad;
        if (done) m_cnt = 1; else if (rd) m_cnt = 0;
      end
    end
    m_prev = m_mode;
    if (ovr) m_oe = 1; else if (lsr) m_oe = 0;
    if (pe_evt) m_pe = 1; else if (lsr) m_pe = 0;
    #1;
    chk(store_o === st, req, "store_o", int'(store_o), int'(st));
    exp_q.push_back({5'b0, m_pe, m_oe, (m_cnt != 0)});
    req_q.push_back(req);
  endtask

  task automatic idle(input string req);
    drive(0, 8'h00, 0, 1, 0, 0, req);
  endtask

  task automatic set_mode(input bit m, input string req);
    m_mode = m;
    idle(req);
  endtask

  // Monitor: compares the status after each clock edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(status_o[2:0] === e[2:0], r, "status[2:0]", int'(status_o[2:0]), int'(e[2:0]));
      chk(status_o[7:3] === 5'd0, "R11", "status[7:3]", int'(status_o[7:3]), 0);
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(status_o === 8'h00, "R1", "status after reset", int'(status_o), 0);
    chk(store_o === 1'b0, "R1", "store after reset", int'(store_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Single-buffer mode: basic receive and read (R2, R3)
    drive(1, 8'h55, 0, 1, 0, 0, "R2");
    idle("R2");
    drive(0, 8'h00, 0, 1, 1, 0, "R3");
    drive(0, 8'h00, 0, 1, 1, 0, "R12");   // read of empty buffer
    idle("R12");

    // Overrun overwrite (R4) and clear on status read (R6)
    drive(1, 8'h0F, 0, 1, 0, 0, "R2");
    drive(1, 8'h33, 0, 1, 0, 0, "R4");
    idle("R4");
    drive(0, 8'h00, 0, 1, 1, 0, "R4");
    drive(0, 8'h00, 0, 1, 0, 1, "R6");
    idle("R6");
    // Read in the same cycle as a new character: no overrun
    drive(1, 8'h11, 0, 1, 0, 0, "R2");
    drive(1, 8'h22, 0, 1, 1, 0, "R4");
    drive(0, 8'h00, 0, 1, 1, 0, "R3");

    // Parity, even and odd selections (R7, R9)
    drive(1, 8'h01, 0, 1, 1, 0, "R7");    // 1 one, even select: bad
    drive(0, 8'h00, 0, 1, 1, 1, "R9");
    drive(1, 8'h03, 0, 0, 0, 0, "R7");    // 2 ones, odd select: bad
    drive(0, 8'h00, 0, 1, 1, 1, "R9");
    drive(1, 8'h03, 1, 0, 0, 0, "R7");    // 3 ones, odd select: good
    drive(1, 8'h81, 1, 1, 1, 0, "R7");    // 3 ones, even select: bad
    drive(0, 8'h00, 0, 1, 1, 1, "R9");

    // Set wins over a coincident status read (R10)
    drive(1, 8'h01, 0, 1, 0, 1, "R10");   // bad parity with read
    drive(1, 8'h00, 0, 1, 0, 1, "R10");   // overrun with read
    drive(0, 8'h00, 0, 1, 0, 1, "R10");
    idle("R10");

    // Mode change flushes storage (R13)
    set_mode(1, "R13");
    idle("R13");

    // FIFO parity reported at the head (R8)
    drive(1, 8'h00, 0, 1, 0, 0, "R8");    // good
    drive(1, 8'h07, 0, 1, 0, 0, "R8");    // bad, waits behind
    drive(1, 8'h00, 0, 1, 0, 0, "R8");
    idle("R8");
    drive(0, 8'h00, 0, 1, 1, 0, "R8");    // bad reaches head
    idle("R8");
    drive(0, 8'h00, 0, 1, 1, 1, "R9");
    drive(0, 8'h00, 0, 1, 1, 0, "R3");
    idle("R3");
    drive(1, 8'h01, 0, 1, 0, 0, "R8");    // bad into empty FIFO
    drive(0, 8'h00, 0, 1, 1, 1, "R3");
    idle("R3");

    // FIFO full: drop and overrun (R5)
    for (int i = 0; i < DEPTH; i++) drive(1, 8'(i), 0, 1, 0, 0, "R5");
    drive(1, 8'hAA, 0, 1, 0, 0, "R5");    // dropped
    idle("R5");
    drive(1, 8'hBB, 0, 1, 1, 1, "R5");    // read frees a slot: stored
    drive(0, 8'h00, 0, 1, 0, 1, "R6");
    for (int i = 0; i < DEPTH - 1; i++) drive(0, 8'h00, 0, 1, 1, 0, "R3");
    drive(0, 8'h00, 0, 1, 1, 0, "R3");    // last read empties
    drive(0, 8'h00, 0, 1, 1, 0, "R12");

    // Back to single-buffer mode with data held (R13)
    drive(1, 8'h00, 0, 1, 0, 0, "R2");
    set_mode(0, "R13");
    idle("R13");
    drive(1, 8'h00, 0, 1, 0, 0, "R2");
    idle("R2");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule